// File: doc/BRIEF.md
# DMA Source Address Sequencer

This block holds the source address of each of two DMA channels and turns a programmed byte count into a string of source transfer requests. Software loads a 32-bit start address through a small host register port, using any mix of byte, halfword or word writes. Each channel register sits at its own fixed offset. A per-channel configuration gives the widest transfer size allowed and says whether the address walks upward or stays put, as it would for a FIFO-style source.

Once started, a channel presents one request at a time. Each request carries an address and a size, and the request stays up until the source side answers with a done or an error pulse. When the start address is not aligned, the channel first issues narrower transfers until the address reaches the configured width. It also shrinks the last transfers to fit the remaining byte count. On an error the channel stops and the register keeps the address of the transfer that failed, so software can read it back. A 64-bit configuration with a start address that is not a multiple of 8 is refused at start.

Top module: `dma_src_seq`

## Requirements
- R1: A host write (`host_sel`=1, `host_we`=1) to a channel offset updates only the bytes whose `host_be` bit is set (bit n covers data bits 8n+7..8n). The register reads back on `host_rdata` in the same cycle that its offset is presented. Any other offset reads 0.
- R2: Channel 0 decodes at offset 0xD10 and channel 1 at 0xE10. A write to one channel leaves the other unchanged.
- R3: The transfer size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. It applies both to `cfg_tsize` and to `req_size`.
- R4: Each request is for the largest power-of-two byte count that is at most the configured width, at most the remaining byte count, and a divisor of the current address.
- R5: After a done response with ascend set, the address grows by the bytes just moved. With ascend clear, the address stays fixed.
- R6: A start with a nonzero `dma_len` raises `busy` on the next cycle. The remaining count shrinks by each completed size, and `busy` drops after the done that empties it. A start with `dma_len`=0 does nothing.
- R7: An error response ends the run at once and sets `xfer_err`. The register keeps the address of the failed request.
- R8: A start with size code 3 and an address whose low three bits are not zero sets `cfg_err`, leaves `busy` low and issues no request.
- R9: Host writes are ignored while the channel is busy, and also in the cycle in which its start is taken. Address updates from responses still happen in those cycles.
- R10: Each start with a nonzero length clears both `xfer_err` and `cfg_err` before any new fault is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when 1 |
| host_addr | input | 12 | Host register offset |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the presented offset |
| dma_start | input | 2 | Start pulse per channel |
| dma_len | input | 32 | Byte count per channel, 16 bits each |
| cfg_tsize | input | 4 | Widest size code per channel, 2 bits each |
| cfg_ascend | input | 2 | Address walks upward when 1 |
| req_valid | output | 2 | Request pending per channel |
| req_addr | output | 64 | Request address per channel |
| req_size | output | 4 | Request size code per channel |
| rsp_done | input | 2 | Transfer completed |
| rsp_err | input | 2 | Transfer failed |
| busy | output | 2 | Channel running |
| xfer_err | output | 2 | Run ended by an error response |
| cfg_err | output | 2 | Start refused for a misaligned 64-bit setup |

## Verification
A host write can land in the same cycle as a done response on a busy channel. It can also land in the same cycle as the start pulse. The bench drives both events in one cycle and then reads the register back. The read must show the address advanced by the completed size, or the untouched start address, and never the written data. The following requests must continue from that address.

// File: rtl/dma_src_pkg.sv
package dma_src_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } xfer_size_e;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;

  localparam int SIZE_W = 2;
  localparam int NUM_SIZES = 4;

endpackage

// File: rtl/dma_src_size_sel.sv
module dma_src_size_sel
  import dma_src_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [2:0]        addr_lo,
  input  logic [CNT_W-1:0]  remain,
  input  logic [SIZE_W-1:0] max_size,
  output logic [SIZE_W-1:0] size
);

  logic [NUM_SIZES-1:0] fit;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_fit
    localparam logic [2:0] LOW_MASK = 3'((1 << k) - 1);
    localparam logic [CNT_W-1:0] NBYTES = CNT_W'(1 << k);
    assign fit[k] = (max_size >= SIZE_W'(k)) &&
                    (remain >= NBYTES) &&
                    ((addr_lo & LOW_MASK) == 3'd0);
  end

  always_comb begin
    size = SZ_BYTE;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (fit[k]) size = SIZE_W'(k);
    end
  end

endmodule

// File: rtl/dma_src_addr_reg.sv
module dma_src_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W/8-1:0] wr_be,
  input  logic [ADDR_W-1:0]   wr_data,
  input  logic                adv_en,
  input  logic [3:0]          adv_step,
  output logic [ADDR_W-1:0]   addr_q
);

  localparam int LANES = ADDR_W / 8;

  logic [ADDR_W-1:0] merged;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[8*l +: 8] = wr_be[l] ? wr_data[8*l +: 8] : addr_q[8*l +: 8];
  end

  always_comb begin
    addr_en = adv_en | wr_en;
    if (adv_en) addr_d = addr_q + ADDR_W'(adv_step);
    else        addr_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

endmodule

// File: rtl/dma_src_chan_ctrl.sv
module dma_src_chan_ctrl
  import dma_src_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic [SIZE_W-1:0] cfg_tsize,
  input  logic              cfg_ascend,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [SIZE_W-1:0] size,
  input  logic              rsp_done,
  input  logic              rsp_err,
  output logic              busy,
  output logic              adv_en,
  output logic [3:0]        adv_step,
  output logic [CNT_W-1:0]  remain,
  output logic [SIZE_W-1:0] tsize_q,
  output logic              xfer_err,
  output logic              cfg_err
);

  ch_state_e         state_q, state_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [SIZE_W-1:0] tsize_d;
  logic              asc_q, asc_d;
  logic              xerr_q, xerr_d;
  logic              cerr_q, cerr_d;
  logic [CNT_W-1:0]  nbytes;
  logic              misaligned_dbl;

  assign nbytes         = CNT_W'(1) << size;
  assign misaligned_dbl = (cfg_tsize == SZ_DBL) && (addr_q[2:0] != 3'd0);

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    tsize_d  = tsize_q;
    asc_d    = asc_q;
    xerr_d   = xerr_q;
    cerr_d   = cerr_q;
    adv_en   = 1'b0;
    unique case (state_q)
      CH_IDLE: begin
        if (start && (len != '0)) begin
          xerr_d = 1'b0;
          cerr_d = misaligned_dbl;
          if (!misaligned_dbl) begin
            state_d  = CH_RUN;
            remain_d = len;
            tsize_d  = cfg_tsize;
            asc_d    = cfg_ascend;
          end
        end
      end
      CH_RUN: begin
        if (rsp_err) begin
          state_d = CH_IDLE;
          xerr_d  = 1'b1;
        end else if (rsp_done) begin
          remain_d = remain_q - nbytes;
          adv_en   = asc_q;
          if (remain_q == nbytes) state_d = CH_IDLE;
        end
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CH_IDLE;
      remain_q <= '0;
      tsize_q  <= SZ_BYTE;
      asc_q    <= 1'b0;
      xerr_q   <= 1'b0;
      cerr_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      tsize_q  <= tsize_d;
      asc_q    <= asc_d;
      xerr_q   <= xerr_d;
      cerr_q   <= cerr_d;
    end
  end

  assign busy     = (state_q == CH_RUN);
  assign remain   = remain_q;
  assign adv_step = 4'(1) << size;
  assign xfer_err = xerr_q;
  assign cfg_err  = cerr_q;

  assert_req_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nbytes <= remain_q) && (size <= tsize_q) &&
             ((addr_q[2:0] & (3'(nbytes) - 3'd1)) == 3'd0));

  assert_err_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_err |=> !busy && xfer_err && $stable(addr_q));

  assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_done && !rsp_err && !asc_q |=> $stable(addr_q));

  assert_last_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_done && !rsp_err && (remain_q == nbytes) |=> !busy);

  assert_dbl_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (len != '0) && (cfg_tsize == SZ_DBL) && (addr_q[2:0] != 3'd0)
    |=> !busy && cfg_err);

endmodule

// File: rtl/dma_src_seq.sv
module dma_src_seq
  import dma_src_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int OFS_W  = 12,
  parameter logic [NCH*OFS_W-1:0] CH_OFS = {12'hE10, 12'hD10}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_sel,
  input  logic                    host_we,
  input  logic [OFS_W-1:0]        host_addr,
  input  logic [ADDR_W/8-1:0]     host_be,
  input  logic [ADDR_W-1:0]       host_wdata,
  output logic [ADDR_W-1:0]       host_rdata,
  input  logic [NCH-1:0]          dma_start,
  input  logic [NCH*CNT_W-1:0]    dma_len,
  input  logic [NCH*SIZE_W-1:0]   cfg_tsize,
  input  logic [NCH-1:0]          cfg_ascend,
  output logic [NCH-1:0]          req_valid,
  output logic [NCH*ADDR_W-1:0]   req_addr,
  output logic [NCH*SIZE_W-1:0]   req_size,
  input  logic [NCH-1:0]          rsp_done,
  input  logic [NCH-1:0]          rsp_err,
  output logic [NCH-1:0]          busy,
  output logic [NCH-1:0]          xfer_err,
  output logic [NCH-1:0]          cfg_err
);

  logic [NCH-1:0]        hit;
  logic [NCH*ADDR_W-1:0] addr_all;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              wr_en;
    logic              adv_en;
    logic [3:0]        adv_step;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size;
    logic [SIZE_W-1:0] tsize_q;
    logic [CNT_W-1:0]  remain;

    assign hit[c] = host_sel && (host_addr == CH_OFS[c*OFS_W +: OFS_W]);
    assign wr_en  = hit[c] && host_we && !busy[c] && !dma_start[c];

    dma_src_addr_reg #(.ADDR_W(ADDR_W)) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_be    (host_be),
      .wr_data  (host_wdata),
      .adv_en   (adv_en),
      .adv_step (adv_step),
      .addr_q   (addr_q)
    );

    dma_src_size_sel #(.CNT_W(CNT_W)) i_size (
      .addr_lo  (addr_q[2:0]),
      .remain   (remain),
      .max_size (tsize_q),
      .size     (size)
    );

    dma_src_chan_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (dma_start[c]),
      .len        (dma_len[c*CNT_W +: CNT_W]),
      .cfg_tsize  (cfg_tsize[c*SIZE_W +: SIZE_W]),
      .cfg_ascend (cfg_ascend[c]),
      .addr_q     (addr_q),
      .size       (size),
      .rsp_done   (rsp_done[c]),
      .rsp_err    (rsp_err[c]),
      .busy       (busy[c]),
      .adv_en     (adv_en),
      .adv_step   (adv_step),
      .remain     (remain),
      .tsize_q    (tsize_q),
      .xfer_err   (xfer_err[c]),
      .cfg_err    (cfg_err[c])
    );

    assign addr_all[c*ADDR_W +: ADDR_W] = addr_q;
    assign req_addr[c*ADDR_W +: ADDR_W] = addr_q;
    assign req_size[c*SIZE_W +: SIZE_W] = size;
    assign req_valid[c]                 = busy[c];

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy[c] && hit[c] && host_we && !rsp_done[c] |=> $stable(addr_q));
  end

  always_comb begin
    host_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hit[c]) host_rdata = addr_all[c*ADDR_W +: ADDR_W];
    end
  end

  assert_one_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: tb/test_dma_src_seq.sv
module test_dma_src_seq;
  localparam int NCH = 2;
  localparam int AW  = 32;
  localparam int CW  = 16;
  localparam int OW  = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic            host_sel, host_we;
  logic [OW-1:0]   host_addr;
  logic [3:0]      host_be;
  logic [AW-1:0]   host_wdata, host_rdata;
  logic [NCH-1:0]  dma_start, cfg_ascend, req_valid, rsp_done, rsp_err;
  logic [NCH-1:0]  busy, xfer_err, cfg_err;
  logic [NCH*CW-1:0] dma_len;
  logic [NCH*2-1:0]  cfg_tsize, req_size;
  logic [NCH*AW-1:0] req_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  dma_src_seq i_dma_src_seq (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dma_start(dma_start), .dma_len(dma_len), .cfg_tsize(cfg_tsize),
    .cfg_ascend(cfg_ascend), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .busy(busy), .xfer_err(xfer_err), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] ofs(input int c);
    return (c == 0) ? 12'hD10 : 12'hE10;
  endfunction

  function automatic int pick_size(input logic [AW-1:0] a, input int rem, input int tsz);
    int s = 0;
    for (int k = 0; k <= tsz; k++)
      if ((1 << k) <= rem && (a % (1 << k)) == 0) s = k;
    return s;
  endfunction

  task automatic host_write(input logic [OW-1:0] o, input logic [3:0] be, input logic [AW-1:0] d);
    host_sel = 1; host_we = 1; host_addr = o; host_be = be; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_we = 0;
  endtask

  task automatic host_read(input logic [OW-1:0] o, output logic [AW-1:0] d);
    host_sel = 1; host_we = 0; host_addr = o;
    #1 d = host_rdata;
    host_sel = 0;
  endtask

  task automatic set_cfg(input int c, input int len, input int tsz, input bit asc);
    dma_len[c*CW +: CW] = CW'(len);
    cfg_tsize[c*2 +: 2] = 2'(tsz);
    cfg_ascend[c] = asc;
  endtask

  task automatic pulse_start(input int c);
    dma_start[c] = 1;
    @(negedge clk);
    dma_start[c] = 0;
  endtask

  // Full run against a bench model; err_idx < 0 means no error response.
  task automatic run_ch(input int c, input logic [AW-1:0] a0, input int len,
                        input int tsz, input bit asc, input int err_idx, input string req);
    logic [AW-1:0] a = a0;
    logic [AW-1:0] rd;
    int rem = len;
    int idx = 0;
    host_write(ofs(c), 4'hF, a0);
    set_cfg(c, len, tsz, asc);
    pulse_start(c);
    while (rem > 0) begin
      int sz = pick_size(a, rem, tsz);
      check(req, "req_valid", 64'(req_valid[c]), 64'd1);
      if (req_valid[c] !== 1'b1) break;
      check(req, "req_addr", 64'(req_addr[c*AW +: AW]), 64'(a));
      check(req, "req_size", 64'(req_size[c*2 +: 2]), 64'(sz));
      if (idx == err_idx) begin
        rsp_err[c] = 1;
        @(negedge clk);
        rsp_err[c] = 0;
        check("R7", "busy after error", 64'(busy[c]), 64'd0);
        check("R7", "xfer_err", 64'(xfer_err[c]), 64'd1);
        host_read(ofs(c), rd);
        check("R7", "frozen address", 64'(rd), 64'(a));
        return;
      end
      rsp_done[c] = 1;
      @(negedge clk);
      rsp_done[c] = 0;
      rem -= (1 << sz);
      if (asc) a += AW'(1 << sz);
      idx++;
    end
    check("R6", "busy after last done", 64'(busy[c]), 64'd0);
    host_read(ofs(c), rd);
    check("R5", "final address", 64'(rd), 64'(a));
  endtask

  task automatic t_reset;
    logic [AW-1:0] rd;
    check("R6", "busy at reset", 64'(busy), 64'd0);
    check("R6", "req_valid at reset", 64'(req_valid), 64'd0);
    host_read(12'hD10, rd);
    check("R1", "reset read ch0", 64'(rd), 64'd0);
  endtask

  task automatic t_lanes;
    logic [AW-1:0] rd;
    host_write(12'hD10, 4'hF, 32'h11223344);
    host_write(12'hD10, 4'b0010, 32'h0000AA00);
    host_read(12'hD10, rd);
    check("R1", "byte lane write", 64'(rd), 64'h1122AA44);
    host_write(12'hD10, 4'b1100, 32'hBEEF0000);
    host_read(12'hD10, rd);
    check("R1", "halfword lane write", 64'(rd), 64'hBEEFAA44);
    host_write(12'hE10, 4'hF, 32'hCAFEF00D);
    host_read(12'hD10, rd);
    check("R2", "ch0 untouched by ch1 write", 64'(rd), 64'hBEEFAA44);
    host_read(12'hE10, rd);
    check("R2", "ch1 readback", 64'(rd), 64'hCAFEF00D);
    host_read(12'hD14, rd);
    check("R1", "unmapped offset", 64'(rd), 64'd0);
  endtask

  task automatic t_cfg_err;
    host_write(12'hD10, 4'hF, 32'h00005004);
    set_cfg(0, 16, 3, 1);
    pulse_start(0);
    check("R8", "cfg_err", 64'(cfg_err[0]), 64'd1);
    check("R10", "xfer_err cleared by start", 64'(xfer_err[0]), 64'd0);
    check("R8", "no request", 64'(req_valid[0]), 64'd0);
    @(negedge clk);
    check("R8", "still idle", 64'(busy[0]), 64'd0);
  endtask

  task automatic t_zero_len;
    set_cfg(1, 0, 2, 1);
    pulse_start(1);
    check("R6", "zero length no run", 64'(busy[1]), 64'd0);
  endtask

  task automatic t_write_with_done;
    logic [AW-1:0] rd;
    host_write(12'hD10, 4'hF, 32'h00006000);
    set_cfg(0, 8, 2, 1);
    pulse_start(0);
    check("R10", "cfg_err cleared by start", 64'(cfg_err[0]), 64'd0);
    rsp_done[0] = 1;
    host_write(12'hD10, 4'hF, 32'hFFFFFFFF);
    rsp_done[0] = 0;
    host_read(12'hD10, rd);
    check("R9", "write lost to done", 64'(rd), 64'h00006004);
    host_write(12'hD10, 4'hF, 32'h0F0F0F0F);
    host_read(12'hD10, rd);
    check("R9", "write while busy", 64'(rd), 64'h00006004);
    check("R9", "req continues", 64'(req_addr[0 +: AW]), 64'h00006004);
    rsp_done[0] = 1;
    @(negedge clk);
    rsp_done[0] = 0;
    check("R6", "idle after two words", 64'(busy[0]), 64'd0);
  endtask

  task automatic t_write_with_start;
    logic [AW-1:0] rd;
    host_write(12'hE10, 4'hF, 32'h00007000);
    set_cfg(1, 4, 2, 1);
    dma_start[1] = 1;
    host_write(12'hE10, 4'hF, 32'h12345678);
    dma_start[1] = 0;
    check("R9", "busy after start", 64'(busy[1]), 64'd1);
    check("R9", "start address kept", 64'(req_addr[AW +: AW]), 64'h00007000);
    check("R3", "word size code", 64'(req_size[2 +: 2]), 64'd2);
    rsp_done[1] = 1;
    @(negedge clk);
    rsp_done[1] = 0;
    host_read(12'hE10, rd);
    check("R5", "advanced by four", 64'(rd), 64'h00007004);
  endtask

  task automatic finish_up;
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0; host_sel = 0; host_we = 0; host_addr = '0; host_be = '0;
    host_wdata = '0; dma_start = '0; dma_len = '0; cfg_tsize = '0;
    cfg_ascend = '0; rsp_done = '0; rsp_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lanes();
    run_ch(0, 32'h00001001, 11, 2, 1'b1, -1, "R4");   // ramp 1,2,4,4
    run_ch(1, 32'h00002000, 13, 3, 1'b1, -1, "R4");   // tail 8,4,1
    run_ch(0, 32'h00003002, 6, 2, 1'b0, -1, "R5");    // hold: three halfwords
    run_ch(1, 32'h00008000, 4, 0, 1'b1, -1, "R3");    // byte code
    run_ch(0, 32'h00004000, 16, 2, 1'b1, 2, "R7");    // error on third
    t_cfg_err();
    t_zero_len();
    t_write_with_done();
    t_write_with_start();
    finish_up();
  end

endmodule